// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Slot Mask

This block derives the two timing strobes a UART needs from a fast reference clock. One strobe is a 16x oversampling tick. The other is a bit-rate tick. A bit period is split into sixteen oversample intervals. Each interval lasts the programmed base length, and may last one extra reference clock. The sum over one bit period can therefore reach divisors that are not whole multiples of sixteen.

There are two ways to choose which intervals get the extra clock. In mask mode, a 16-bit slot pattern selects them directly, one bit per interval. Software places the extra clocks evenly, for example 0x0080 for one clock, 0x5555 for eight and 0xffdf for fifteen. In remainder mode, a 4-bit count of extra clocks per bit period is spread evenly by a phase accumulator. Software writes divisor, pattern and remainder through a small write port into holding registers. The active copies change only at a bit-period boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: In mask mode, one bit period spans 16*(D+1) + popcount(M) reference clocks, where D is the divisor value and M is the slot pattern.
- R2: In mask mode, oversample interval s (s = 0 first after a boundary, s = 15 last) lasts D+1+M[s] reference clocks, where M[s] is bit s of the pattern.
- R3: In remainder mode with remainder r, interval s lasts D+1+floor((s+1)*r/16)-floor(s*r/16) clocks, so a bit period spans 16*(D+1)+r clocks. The slot pattern has no effect in this mode.
- R4: os_tick is a one-clock pulse in the last clock of every interval. bit_tick is high only together with the sixteenth os_tick of a bit period.
- R5: A write with wr_en high stores wr_data into a holding register: address 0 holds the divisor (low DIV_W bits), address 1 the slot pattern, address 2 the remainder (low 4 bits). While the generator runs, a stored value takes effect at the first interval after the next bit_tick.
- R6: While enable is low, neither tick is produced and the interval and slot state clear. After enable rises, the first os_tick comes in the cycle that completes a full interval 0.
- R7: A synchronous active-low reset clears all holding and active registers and suppresses both ticks. After the reset is released with enable high, every interval lasts one clock.
- R8: The mode_rem input (1 = remainder mode, 0 = mask mode) is sampled at a bit-period boundary, or continuously while enable is low. A bit period in progress keeps the mode it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator when high |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_addr | input | 2 | Register select: 0 divisor, 1 slot pattern, 2 remainder |
| wr_data | input | 16 | Write data |
| mode_rem | input | 1 | 1 selects remainder mode, 0 selects mask mode |
| os_tick | output | 1 | Oversample tick, one clock wide |
| bit_tick | output | 1 | Bit-rate tick, one clock wide |

## Verification
Both ticks are decoded combinationally from registered state. A tick is therefore visible in the same cycle in which the interval counter reaches its last value. The first tick after enable rises appears in cycle D+1+extra, counting the cycle in which enable is first high as cycle 1. The bench samples the outputs two nanoseconds after each falling edge and counts samples from the cycle in which it raised enable or saw the previous tick. The count at each tick is compared with the formula for that slot.

A holding-register write needs one edge to reach the holding register. A boundary then moves it to the active set. Writes are therefore placed mid-period, and the expected lengths change only from the interval after the next bit_tick. A mode change issued just after a boundary is expected to show one full period later.

// File: rtl/frac_baud_pkg.sv
`timescale 1ns/1ps
// Shared constants and the register select encoding of the fractional
// baud tick generator. Assumes a bit period of sixteen oversample slots.
package frac_baud_pkg;
    localparam int SLOTS  = 16;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int MASK_W = SLOTS;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_REM  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/frac_baud_regs.sv
`timescale 1ns/1ps
// Holding and active configuration registers.
// Writes land in holding registers. The active set copies them while the
// generator is disabled and at each bit-period boundary, so a running
// period never mixes old and new settings. Assumes DIV_W <= DATA_W.
module frac_baud_regs
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_rem,
    output logic [DIV_W-1:0]  div_act,
    output logic [MASK_W-1:0] mask_act,
    output logic [SLOT_W-1:0] rem_act,
    output logic              mode_act
);
    logic [DIV_W-1:0]  div_hold;
    logic [MASK_W-1:0] mask_hold;
    logic [SLOT_W-1:0] rem_hold;
    logic              load_act;

    assign load_act = !enable || bit_tick;

    // Capture software writes into the holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_hold  <= '0;
            mask_hold <= '0;
            rem_hold  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_DIV:  div_hold  <= wr_data[DIV_W-1:0];
                SEL_MASK: mask_hold <= wr_data[MASK_W-1:0];
                SEL_REM:  rem_hold  <= wr_data[SLOT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Move holding values into the active set at a boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act  <= '0;
            mask_act <= '0;
            rem_act  <= '0;
            mode_act <= 1'b0;
        end else if (load_act) begin
            div_act  <= div_hold;
            mask_act <= mask_hold;
            rem_act  <= rem_hold;
            mode_act <= mode_rem;
        end
    end
endmodule

// File: rtl/frac_baud_slot.sv
`timescale 1ns/1ps
// Slot pointer and per-interval extension decision.
// Tracks which of the sixteen oversample slots is running. Tells the
// interval counter whether the current slot gets one extra clock, taken
// from the slot pattern or from the carry of a phase accumulator.
// Assumes os_tick marks the last clock of an interval.
module frac_baud_slot
    import frac_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              os_tick,
    input  logic [MASK_W-1:0] mask_act,
    input  logic [SLOT_W-1:0] rem_act,
    input  logic              mode_act,
    output logic              extra,
    output logic              bit_tick
);
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] phase_q;
    logic [SLOT_W:0]   phase_sum;

    assign phase_sum = {1'b0, phase_q} + {1'b0, rem_act};

    // Choose the source of the extra clock for the current slot.
    always_comb begin
        if (mode_act) extra = phase_sum[SLOT_W];
        else          extra = mask_act[slot_q];
    end

    assign bit_tick = os_tick && (slot_q == SLOT_W'(SLOTS - 1));

    // Advance the slot pointer and the phase on each oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            slot_q  <= '0;
            phase_q <= '0;
        end else if (os_tick) begin
            slot_q  <= slot_q + 1'b1;
            phase_q <= bit_tick ? '0 : phase_sum[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/frac_baud_count.sv
`timescale 1ns/1ps
// Oversample interval counter.
// Counts reference clocks within one slot. It raises os_tick in the last
// clock, after div_act + 1 + extra clocks. Assumes extra is stable for
// the whole interval.
module frac_baud_count #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_act,
    input  logic             extra,
    output logic             os_tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    assign last_val = {1'b0, div_act} + CNT_W'(extra);
    assign os_tick  = rst_n && enable && (cnt_q == last_val);

    // Count clocks in the slot and restart after the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (os_tick)      cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
// Fractional baud tick generator, top level.
// Links the configuration registers, the slot and extension logic and the
// interval counter. Produces a 16x oversample tick and a bit tick from the
// reference clock. Assumes a single clock domain for writes and ticks.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_rem,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [DIV_W-1:0]  div_act;
    logic [MASK_W-1:0] mask_act;
    logic [SLOT_W-1:0] rem_act;
    logic              mode_act;
    logic              extra;

    frac_baud_regs #(.DIV_W(DIV_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .bit_tick (bit_tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_rem (mode_rem),
        .div_act  (div_act),
        .mask_act (mask_act),
        .rem_act  (rem_act),
        .mode_act (mode_act)
    );

    frac_baud_slot slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .os_tick  (os_tick),
        .mask_act (mask_act),
        .rem_act  (rem_act),
        .mode_act (mode_act),
        .extra    (extra),
        .bit_tick (bit_tick)
    );

    frac_baud_count #(.DIV_W(DIV_W)) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_act (div_act),
        .extra   (extra),
        .os_tick (os_tick)
    );
endmodule

// File: rtl/frac_baud_chk.sv
`timescale 1ns/1ps
// Assertion checker for frac_baud_gen, attached by bind.
// Keeps its own clock-gap and tick counters. From them it checks the tick
// spacing, the placement of the bit tick and that the active settings are
// held during a period.
module frac_baud_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [DIV_W-1:0] div_act
);
    logic [DIV_W+1:0] gap_q;
    logic [3:0]       os_cnt_q;

    // Count clocks since the last oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) gap_q <= '0;
        else if (os_tick)      gap_q <= '0;
        else                   gap_q <= gap_q + 1'b1;
    end

    // Count oversample ticks modulo sixteen since enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) os_cnt_q <= '0;
        else if (os_tick)      os_cnt_q <= os_cnt_q + 1'b1;
    end

    assert_interval_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> (gap_q >= {2'b00, div_act}) && (gap_q <= {2'b00, div_act} + 1'b1));

    assert_bit_needs_os_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_bit_sixteenth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> (bit_tick == (os_cnt_q == 4'd15)));

    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!os_tick && !bit_tick));

    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_tick) |=> $stable(div_act));
endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .div_act  (div_act)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        mode_rem = 1'b0;
    logic        os_tick;
    logic        bit_tick;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    frac_baud_gen #(.DIV_W(12)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_rem (mode_rem),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Expected interval length from the requirement formulas (R2, R3).
    function automatic int exp_len(int div, int mask, int rem, bit mode, int s);
        if (mode) return div + 1 + ((s + 1) * rem) / 16 - (s * rem) / 16;
        return div + 1 + ((mask >> s) & 1);
    endfunction

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    // Disable, program the holding registers, leave enable low at a negedge.
    task automatic setup(int div, int mask, int rem, bit mode);
        @(negedge clk);
        enable = 1'b0;
        wr(0, div); wr(1, mask); wr(2, rem);
        mode_rem = mode;
        repeat (3) @(negedge clk);
    endtask

    // Measure interval lengths; optional write in the first period at wr_slot.
    task automatic measure(int periods, int div, int mask, int rem, bit mode,
                           string req, int wr_slot = -1, int wa = 0, int wd = 0);
        enable = 1'b1;
        for (int p = 0; p < periods; p++) begin
            int tot = 0;
            for (int s = 0; s < 16; s++) begin
                int c = 0;
                bit tk = 1'b0;
                bit bt = 1'b0;
                while (!tk && c < 5000) begin
                    #2;
                    c++;
                    tk = os_tick;
                    bt = bit_tick;
                    @(negedge clk);
                    if (p == 0 && s == wr_slot && c == 1 && !tk) begin
                        wr_en = 1'b1; wr_addr = wa[1:0]; wr_data = wd[15:0];
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                check(c == exp_len(div, mask, rem, mode, s), req, c,
                      exp_len(div, mask, rem, mode, s));
                check(bt == (s == 15), "R4", int'(bt), int'(s == 15));
                tot += c;
            end
            if (mode)
                check(tot == 16 * (div + 1) + rem, "R3", tot, 16 * (div + 1) + rem);
            else
                check(tot == 16 * (div + 1) + $countones(mask[15:0]), "R1", tot,
                      16 * (div + 1) + $countones(mask[15:0]));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int masks[6] = '{0, 'h0080, 'h5555, 'hffdf, 'hffff, 'h8001};
        int divs[4]  = '{0, 1, 2, 5};
        // R7: ticks held off in reset even with enable high.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #2;
            check(os_tick == 1'b0 && bit_tick == 1'b0, "R7", int'(os_tick), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        measure(1, 0, 0, 0, 1'b0, "R7");

        // R1/R2: mask mode sweep.
        foreach (divs[i]) foreach (masks[j]) begin
            setup(divs[i], masks[j], 0, 1'b0);
            measure(2, divs[i], masks[j], 0, 1'b0, "R2");
        end

        // R3: remainder mode, every remainder, pattern held non-zero to show it is ignored.
        for (int d = 0; d < 4; d += 3) begin
            for (int r = 0; r < 16; r++) begin
                setup(d, 'ha5a5, r, 1'b1);
                measure(2, d, 'ha5a5, r, 1'b1, "R3");
            end
        end

        // R6: disable mid-interval, no ticks while low, full first interval.
        setup(4, 0, 0, 1'b0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 10; i++) begin
            #2;
            check(os_tick == 1'b0 && bit_tick == 1'b0, "R6", int'(os_tick), 0);
            @(negedge clk);
        end
        measure(1, 4, 0, 0, 1'b0, "R6");

        // R5: mid-period writes take effect after the next bit tick.
        setup(3, 0, 0, 1'b0);
        measure(1, 3, 0, 0, 1'b0, "R5", 5, 0, 6);
        measure(1, 6, 0, 0, 1'b0, "R5", 2, 1, 'h5555);
        measure(1, 6, 'h5555, 0, 1'b0, "R5", 3, 2, 9);

        // R8: mode change after a boundary shows one period later.
        mode_rem = 1'b1;
        measure(1, 6, 'h5555, 9, 1'b0, "R8");
        measure(1, 6, 'h5555, 9, 1'b1, "R8");

        report();
    end
endmodule